// File: doc/BRIEF.md
# Pipelined Binary Floating-Point Adder

This block adds or subtracts two floating-point words, each made of a sign bit, a biased exponent and a fraction. The default widths give the common 32-bit single-precision word: sign in bit 31, an 8-bit exponent with bias 127 in bits 30..23, and a 23-bit fraction in bits 22..0. Both widths are parameters, so the same unit can be built for narrower formats. One operation can be issued on every clock. Each result appears a fixed number of cycles later, together with an overflow flag and an invalid-operation flag.

The datapath has three steps. The first step unpacks both operands, classifies the special encodings and swaps the operands so that the larger magnitude comes first. The second step shifts the smaller significand right to line it up with the larger one, keeping guard, round and sticky bits, and then adds or subtracts the two. The third step counts leading zeros, normalizes the sum, adjusts the exponent and rounds to nearest-even. The exponent field is biased by 2^(EXP_W-1)-1. Fields 1 to all-ones-minus-one carry a hidden 1. A zero field means a hidden 0 and the minimum true exponent, which covers zero and denormals. An all-ones field means infinity when the fraction is zero and NaN otherwise. Denormal inputs and denormal results are fully supported.

Top module: `fp_add_pipe`

## Requirements
- R1: With the default MID_REG=1, a result and its `out_valid` appear exactly 3 clock edges after the operation is presented with `in_valid` high. Back-to-back operations are accepted on every cycle, and `out_valid` is low after reset.
- R2: For finite operands, `result` is the exact sum rounded to nearest with ties to even, in normal or denormal form as the magnitude requires.
- R3: When `sub` is 1 the result equals the sum of `op_a` and `op_b` with the sign bit of `op_b` inverted.
- R4: A result whose exact value is zero is the all-zero word (+0), whatever the operand signs.
- R5: Any NaN input (exponent all ones, fraction nonzero) produces the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and the other fraction bits 0 (0x7FC00000 at default widths).
- R6: The sum of two infinities of opposite effective sign, or any input NaN whose fraction MSB is 0, produces the canonical quiet NaN with `inv_flag` set. A quiet NaN input does not set `inv_flag`.
- R7: An infinity combined with a finite operand, or with an infinity of the same effective sign, returns that infinity with both flags clear.
- R8: A finite sum whose rounded exponent reaches all ones returns an infinity of the sum's sign (fraction 0) with `ovf_flag` set.
- R9: `ovf_flag` and `inv_flag` are 0 in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| sub | input | 1 | 1 = subtract op_b from op_a |
| out_valid | output | 1 | Result valid |
| result | output | EXP_W+FRAC_W+1 | Rounded sum or difference |
| ovf_flag | output | 1 | Finite operands overflowed to infinity |
| inv_flag | output | 1 | Invalid operation produced the quiet NaN |

## Verification
A wrong swap decision or a wrong alignment distance shows up as a result several units off, on the very operation that caused it, three edges after issue. A wrong leading-zero count or a wrong exponent adjustment shows up either as results off by powers of two or as denormal results in the wrong form. A wrong rounding increment shows up only in the last bit on ties and near-ties.

The pipeline carries no state between operations, so every fault is tied to a specific operand pair. For that reason, an exhaustive sweep of a narrow 8-bit format, compared against an exact integer sum, reaches every exponent difference, every cancellation depth and every rounding case. Directed words at full width then confirm the default parameterization.

// File: rtl/fp_add_pkg.sv
package fp_add_pkg;
   typedef enum logic [2:0] {
      FC_ZERO,
      FC_SUBN,
      FC_NORM,
      FC_INF,
      FC_QNAN,
      FC_SNAN
   } fp_class_e;

   localparam int unsigned GRS_BITS = 3;
endpackage

// File: rtl/fp_add_lzc.sv
module fp_add_lzc #(
   parameter int unsigned WIDTH = 28,
   localparam int unsigned CW   = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] vec,
   output logic [CW-1:0]    zeros
);
   always_comb begin
      zeros = CW'(WIDTH);
      for (int i = 0; i < int'(WIDTH); i++) begin
         if (vec[i]) zeros = CW'(int'(WIDTH) - 1 - i);
      end
   end
endmodule

// File: rtl/fp_add_swap.sv
module fp_add_swap
   import fp_add_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned WORD  = EXP_W + FRAC_W + 1,
   localparam int unsigned SIG   = FRAC_W + 1
) (
   input  logic [WORD-1:0]  a,
   input  logic [WORD-1:0]  b,
   input  logic             sub,
   output logic             big_sign,
   output logic             eff_sub,
   output logic [EXP_W-1:0] big_exp,
   output logic [SIG-1:0]   big_sig,
   output logic [SIG-1:0]   small_sig,
   output logic [EXP_W-1:0] exp_diff,
   output logic             spec_hit,
   output logic [WORD-1:0]  spec_word,
   output logic             spec_inv
);
   localparam logic [WORD-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   function automatic fp_class_e classify(input logic [WORD-1:0] v);
      logic [EXP_W-1:0]  e;
      logic [FRAC_W-1:0] f;
      e = v[WORD-2:FRAC_W];
      f = v[FRAC_W-1:0];
      if (&e) begin
         if (f == '0)          return FC_INF;
         else if (f[FRAC_W-1]) return FC_QNAN;
         else                  return FC_SNAN;
      end else if (e == '0) begin
         return (f == '0) ? FC_ZERO : FC_SUBN;
      end
      return FC_NORM;
   endfunction

   logic [WORD-1:0]  b_eff;
   fp_class_e        cls_a, cls_b;
   logic [EXP_W-1:0] ea, eb;
   logic [SIG-1:0]   sa, sb;
   logic             a_first;

   always_comb begin
      b_eff = {b[WORD-1] ^ sub, b[WORD-2:0]};
      cls_a = classify(a);
      cls_b = classify(b_eff);
      ea    = (a[WORD-2:FRAC_W] == '0) ? EXP_W'(1) : a[WORD-2:FRAC_W];
      eb    = (b_eff[WORD-2:FRAC_W] == '0) ? EXP_W'(1) : b_eff[WORD-2:FRAC_W];
      sa    = {(a[WORD-2:FRAC_W] != '0), a[FRAC_W-1:0]};
      sb    = {(b_eff[WORD-2:FRAC_W] != '0), b_eff[FRAC_W-1:0]};
      a_first = {ea, sa} >= {eb, sb};

      big_sign  = a_first ? a[WORD-1] : b_eff[WORD-1];
      eff_sub   = a[WORD-1] ^ b_eff[WORD-1];
      big_exp   = a_first ? ea : eb;
      big_sig   = a_first ? sa : sb;
      small_sig = a_first ? sb : sa;
      exp_diff  = a_first ? (ea - eb) : (eb - ea);

      spec_hit  = 1'b0;
      spec_word = '0;
      spec_inv  = 1'b0;
      if (cls_a inside {FC_QNAN, FC_SNAN} || cls_b inside {FC_QNAN, FC_SNAN}) begin
         spec_hit  = 1'b1;
         spec_word = QNAN;
         spec_inv  = (cls_a == FC_SNAN) || (cls_b == FC_SNAN);
      end else if (cls_a == FC_INF && cls_b == FC_INF) begin
         spec_hit  = 1'b1;
         spec_word = eff_sub ? QNAN : a;
         spec_inv  = eff_sub;
      end else if (cls_a == FC_INF) begin
         spec_hit  = 1'b1;
         spec_word = a;
      end else if (cls_b == FC_INF) begin
         spec_hit  = 1'b1;
         spec_word = b_eff;
      end
   end
endmodule

// File: rtl/fp_add_align.sv
module fp_add_align
   import fp_add_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned SIG   = FRAC_W + 1,
   localparam int unsigned SHW   = SIG + GRS_BITS,
   localparam int unsigned SUMW  = SHW + 1
) (
   input  logic [SIG-1:0]   big_sig,
   input  logic [SIG-1:0]   small_sig,
   input  logic [EXP_W-1:0] exp_diff,
   input  logic             eff_sub,
   output logic [SUMW-1:0]  sum
);
   logic [SHW-1:0]  small_val, shifted, lost;
   logic            sticky;
   logic [SUMW-1:0] big_ext, small_ext;

   always_comb begin
      small_val = {small_sig, {GRS_BITS{1'b0}}};
      if (int'(exp_diff) >= int'(SHW)) begin
         shifted = '0;
         lost    = small_val;
      end else begin
         shifted = small_val >> exp_diff;
         lost    = small_val & ~({SHW{1'b1}} << exp_diff);
      end
      sticky    = |lost;
      big_ext   = {1'b0, big_sig, {GRS_BITS{1'b0}}};
      small_ext = {1'b0, shifted[SHW-1:1], shifted[0] | sticky};
      sum       = eff_sub ? (big_ext - small_ext) : (big_ext + small_ext);
   end
endmodule

// File: rtl/fp_add_norm_round.sv
module fp_add_norm_round
   import fp_add_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned WORD  = EXP_W + FRAC_W + 1,
   localparam int unsigned SUMW  = FRAC_W + 1 + GRS_BITS + 1,
   localparam int unsigned CW    = $clog2(SUMW + 1),
   localparam int unsigned XE    = (EXP_W + 2 > CW + 1) ? EXP_W + 2 : CW + 1
) (
   input  logic [SUMW-1:0]  sum,
   input  logic [EXP_W-1:0] exp_in,
   input  logic             sign,
   output logic [WORD-1:0]  word,
   output logic             ovf
);
   localparam logic [XE-1:0] EXP_TOP = XE'((1 << EXP_W) - 1);

   logic [CW-1:0]     lz;
   logic [XE-1:0]     lz_x, exp_x, room, lz1, sh, exp_n, exp_f;
   logic [SUMW-2:0]   norm;
   logic [FRAC_W:0]   mant;
   logic [FRAC_W+1:0] mant_r;
   logic              inc;
   logic [FRAC_W-1:0] frac_f;

   fp_add_lzc #(.WIDTH(SUMW)) u_lzc (
      .vec   (sum),
      .zeros (lz)
   );

   always_comb begin
      lz_x  = XE'(lz);
      exp_x = XE'(exp_in);
      room  = exp_x - XE'(1);
      lz1   = lz_x - XE'(1);
      sh    = '0;
      if (sum[SUMW-1]) begin
         norm  = {sum[SUMW-1:2], sum[1] | sum[0]};
         exp_n = exp_x + XE'(1);
      end else begin
         sh    = (lz1 <= room) ? lz1 : room;
         norm  = sum[SUMW-2:0] << sh;
         exp_n = exp_x - sh;
      end
      mant   = norm[SUMW-2:GRS_BITS];
      inc    = norm[2] & (norm[1] | norm[0] | mant[0]);
      mant_r = {1'b0, mant} + (FRAC_W+2)'(inc);
      if (mant_r[FRAC_W+1]) begin
         exp_f  = exp_n + XE'(1);
         frac_f = '0;
      end else begin
         exp_f  = mant_r[FRAC_W] ? exp_n : '0;
         frac_f = mant_r[FRAC_W-1:0];
      end
      ovf  = 1'b0;
      if (sum == '0) begin
         word = '0;
      end else if (exp_f >= EXP_TOP) begin
         word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         ovf  = 1'b1;
      end else begin
         word = {sign, exp_f[EXP_W-1:0], frac_f};
      end
   end
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe
   import fp_add_pkg::*;
#(
   parameter int unsigned EXP_W   = 8,
   parameter int unsigned FRAC_W  = 23,
   parameter bit          MID_REG = 1'b1,
   localparam int unsigned WORD   = EXP_W + FRAC_W + 1,
   localparam int unsigned SIG    = FRAC_W + 1,
   localparam int unsigned SUMW   = SIG + GRS_BITS + 1,
   localparam int unsigned LATENCY = 2 + int'(MID_REG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [WORD-1:0] op_a,
   input  logic [WORD-1:0] op_b,
   input  logic            sub,
   output logic            out_valid,
   output logic [WORD-1:0] result,
   output logic            ovf_flag,
   output logic            inv_flag
);
   generate
      if (EXP_W < 3 || FRAC_W < 2) begin : g_bad_cfg
         $error("fp_add_pipe: EXP_W must be >= 3 and FRAC_W >= 2");
      end
   endgenerate

   // step 1: classify and order
   logic             c_sign, c_sub, c_spec, c_sinv;
   logic [EXP_W-1:0] c_exp, c_diff;
   logic [SIG-1:0]   c_bsig, c_ssig;
   logic [WORD-1:0]  c_sword;

   fp_add_swap #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_swap (
      .a         (op_a),
      .b         (op_b),
      .sub       (sub),
      .big_sign  (c_sign),
      .eff_sub   (c_sub),
      .big_exp   (c_exp),
      .big_sig   (c_bsig),
      .small_sig (c_ssig),
      .exp_diff  (c_diff),
      .spec_hit  (c_spec),
      .spec_word (c_sword),
      .spec_inv  (c_sinv)
   );

   logic             s1_v, s1_sign, s1_sub, s1_spec, s1_sinv;
   logic [EXP_W-1:0] s1_exp, s1_diff;
   logic [SIG-1:0]   s1_bsig, s1_ssig;
   logic [WORD-1:0]  s1_sword;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_sign <= 1'b0; s1_sub <= 1'b0; s1_spec <= 1'b0; s1_sinv <= 1'b0;
         s1_exp <= '0; s1_diff <= '0; s1_bsig <= '0; s1_ssig <= '0; s1_sword <= '0;
      end else begin
         s1_v <= in_valid; s1_sign <= c_sign; s1_sub <= c_sub; s1_spec <= c_spec;
         s1_sinv <= c_sinv; s1_exp <= c_exp; s1_diff <= c_diff; s1_bsig <= c_bsig;
         s1_ssig <= c_ssig; s1_sword <= c_sword;
      end
   end

   // step 2: align and add
   logic [SUMW-1:0] a_sum;

   fp_add_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .big_sig   (s1_bsig),
      .small_sig (s1_ssig),
      .exp_diff  (s1_diff),
      .eff_sub   (s1_sub),
      .sum       (a_sum)
   );

   logic             s2_v, s2_sign, s2_spec, s2_sinv;
   logic [EXP_W-1:0] s2_exp;
   logic [SUMW-1:0]  s2_sum;
   logic [WORD-1:0]  s2_sword;

   generate
      if (MID_REG) begin : g_mid_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s2_v <= 1'b0; s2_sign <= 1'b0; s2_spec <= 1'b0; s2_sinv <= 1'b0;
               s2_exp <= '0; s2_sum <= '0; s2_sword <= '0;
            end else begin
               s2_v <= s1_v; s2_sign <= s1_sign; s2_spec <= s1_spec; s2_sinv <= s1_sinv;
               s2_exp <= s1_exp; s2_sum <= a_sum; s2_sword <= s1_sword;
            end
         end
      end else begin : g_mid_wire
         always_comb begin
            s2_v = s1_v; s2_sign = s1_sign; s2_spec = s1_spec; s2_sinv = s1_sinv;
            s2_exp = s1_exp; s2_sum = a_sum; s2_sword = s1_sword;
         end
      end
   endgenerate

   // step 3: normalize and round
   logic [WORD-1:0] n_word;
   logic            n_ovf;

   fp_add_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
      .sum    (s2_sum),
      .exp_in (s2_exp),
      .sign   (s2_sign),
      .word   (n_word),
      .ovf    (n_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         ovf_flag  <= 1'b0;
         inv_flag  <= 1'b0;
      end else begin
         out_valid <= s2_v;
         result    <= s2_spec ? s2_sword : n_word;
         ovf_flag  <= s2_v & ~s2_spec & n_ovf;
         inv_flag  <= s2_v & s2_spec & s2_sinv;
      end
   end
endmodule

// File: rtl/fp_add_pipe_chk.sv
module fp_add_pipe_chk #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   parameter int unsigned LAT    = 3,
   localparam int unsigned WORD  = EXP_W + FRAC_W + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            out_valid,
   input logic [WORD-1:0] result,
   input logic            ovf_flag,
   input logic            inv_flag
);
   localparam logic [WORD-1:0] QNAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic [WORD-1:0] NEG_ZERO = {1'b1, {(WORD-1){1'b0}}};

   logic [LAT-1:0] vhist;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vhist <= '0;
      else        vhist <= {vhist[LAT-2:0], in_valid};
   end

   logic exp_ones, frac_zero;
   assign exp_ones  = &result[WORD-2:FRAC_W];
   assign frac_zero = (result[FRAC_W-1:0] == '0);

   AST_LATENCY:   assert property (@(posedge clk) disable iff (!rst_n) out_valid == vhist[LAT-1]); // R1
   AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> result != NEG_ZERO); // R4
   AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && exp_ones && !frac_zero) |-> result == QNAN); // R5
   AST_INV_QNAN:  assert property (@(posedge clk) disable iff (!rst_n) inv_flag |-> result == QNAN); // R6
   AST_OVF_INF:   assert property (@(posedge clk) disable iff (!rst_n) ovf_flag |-> (exp_ones && frac_zero)); // R8
   AST_FLAG_GATE: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (!ovf_flag && !inv_flag)); // R9
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ovf_flag && inv_flag)); // R6
endmodule

bind fp_add_pipe fp_add_pipe_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W),
   .LAT    (LATENCY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .result    (result),
   .ovf_flag  (ovf_flag),
   .inv_flag  (inv_flag)
);

// File: tb/fp_add_pipe_bench.sv
`timescale 1ns/1ps
module fp_add_pipe_bench;
   localparam int SE = 4;
   localparam int SF = 3;
   localparam int SW = SE + SF + 1;
   localparam int EMAX = (1 << SE) - 1;
   localparam logic [SW-1:0] SQN = {1'b0, {SE{1'b1}}, 1'b1, {(SF-1){1'b0}}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // narrow instance, swept exhaustively
   logic          s_in_valid = 1'b0, s_sub = 1'b0;
   logic [SW-1:0] s_a = '0, s_b = '0;
   logic          s_out_valid, s_ovf, s_inv;
   logic [SW-1:0] s_res;

   fp_add_pipe #(.EXP_W(SE), .FRAC_W(SF)) u_fp_add_pipe (
      .clk (clk), .rst_n (rst_n), .in_valid (s_in_valid),
      .op_a (s_a), .op_b (s_b), .sub (s_sub),
      .out_valid (s_out_valid), .result (s_res), .ovf_flag (s_ovf), .inv_flag (s_inv)
   );

   // full-width instance, directed words
   logic        f_in_valid = 1'b0, f_sub = 1'b0;
   logic [31:0] f_a = '0, f_b = '0;
   logic        f_out_valid, f_ovf, f_inv;
   logic [31:0] f_res;

   fp_add_pipe u_fp_add_pipe_full (
      .clk (clk), .rst_n (rst_n), .in_valid (f_in_valid),
      .op_a (f_a), .op_b (f_b), .sub (f_sub),
      .out_valid (f_out_valid), .result (f_res), .ovf_flag (f_ovf), .inv_flag (f_inv)
   );

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   function automatic bit w_nan(input logic [SW-1:0] v);
      return (int'(v[SW-2:SF]) == EMAX) && (v[SF-1:0] != '0);
   endfunction
   function automatic bit w_inf(input logic [SW-1:0] v);
      return (int'(v[SW-2:SF]) == EMAX) && (v[SF-1:0] == '0);
   endfunction
   function automatic longint w_mag(input logic [SW-1:0] v);
      int e;
      longint sig;
      e = int'(v[SW-2:SF]);
      sig = longint'(v[SF-1:0]) + ((e == 0) ? 0 : (longint'(1) << SF));
      return sig << (((e == 0) ? 1 : e) - 1);
   endfunction

   // exact integer sum in units of the smallest denormal, then nearest-even
   function automatic void ref_add(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                   input logic sub, output logic [SW-1:0] r,
                                   output logic ov, output logic iv);
      logic [SW-1:0] bb;
      longint sum, m, mant, rem, half;
      int k, ef;
      logic s;
      bb = {b[SW-1] ^ sub, b[SW-2:0]};
      r = '0; ov = 1'b0; iv = 1'b0;
      if (w_nan(a) || w_nan(bb)) begin
         r  = SQN;
         iv = (w_nan(a) && !a[SF-1]) || (w_nan(bb) && !bb[SF-1]);
         return;
      end
      if (w_inf(a) && w_inf(bb)) begin
         if (a[SW-1] != bb[SW-1]) begin r = SQN; iv = 1'b1; end
         else r = a;
         return;
      end
      if (w_inf(a))  begin r = a;  return; end
      if (w_inf(bb)) begin r = bb; return; end
      sum = (a[SW-1] ? -w_mag(a) : w_mag(a)) + (bb[SW-1] ? -w_mag(bb) : w_mag(bb));
      if (sum == 0) return;
      s = (sum < 0);
      m = s ? -sum : sum;
      k = 0;
      while (m >= (longint'(2) << (SF + k))) k++;
      mant = m >> k;
      rem  = m - (mant << k);
      if (k > 0) begin
         half = longint'(1) << (k - 1);
         if (rem > half || (rem == half && (mant % 2) == 1)) mant++;
      end
      if (mant == (longint'(1) << (SF + 1))) begin mant = mant >> 1; k++; end
      ef = (mant >= (longint'(1) << SF)) ? k + 1 : 0;
      if (ef >= EMAX) begin
         r  = {s, {SE{1'b1}}, {SF{1'b0}}};
         ov = 1'b1;
         return;
      end
      r = {s, ef[SE-1:0], mant[SF-1:0]};
   endfunction

   // expected-value ring for the streamed narrow instance
   logic [SW-1:0] q_res [16];
   logic          q_ov  [16];
   logic          q_iv  [16];
   logic [SW-1:0] q_a   [16];
   logic [SW-1:0] q_b   [16];
   string         q_tag [16];
   int wr = 0, rd = 0, issued = 0, popped = 0;

   always @(negedge clk) begin
      if (rst_n && s_out_valid) begin
         checks++;
         if (s_res !== q_res[rd] || s_ovf !== q_ov[rd] || s_inv !== q_iv[rd]) begin
            errors++;
            $display("FAIL %s a=%h b=%h got res=%h ovf=%b inv=%b exp res=%h ovf=%b inv=%b",
                     q_tag[rd], q_a[rd], q_b[rd], s_res, s_ovf, s_inv, q_res[rd], q_ov[rd], q_iv[rd]);
         end
         rd = (rd + 1) % 16;
         popped++;
      end
   end

   task automatic issue_small(input logic [SW-1:0] a, input logic [SW-1:0] b, input logic sb);
      logic [SW-1:0] r;
      logic ov, iv;
      ref_add(a, b, sb, r, ov, iv);
      q_res[wr] = r; q_ov[wr] = ov; q_iv[wr] = iv; q_a[wr] = a; q_b[wr] = b;
      if (iv)                         q_tag[wr] = "R6";
      else if (r == SQN)              q_tag[wr] = "R5";
      else if (ov)                    q_tag[wr] = "R8";
      else if (w_inf(r))              q_tag[wr] = "R7";
      else if (r == '0)               q_tag[wr] = "R4";
      else if (sb)                    q_tag[wr] = "R3";
      else                            q_tag[wr] = "R2";
      wr = (wr + 1) % 16;
      issued++;
      s_a = a; s_b = b; s_sub = sb; s_in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_bit(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %b exp %b", tag, got, exp);
      end
   endtask

   task automatic full_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic sb, input logic [31:0] er, input logic eo, input logic ei,
                          input bit chk_lat);
      @(negedge clk);
      f_a = a; f_b = b; f_sub = sb; f_in_valid = 1'b1;
      @(negedge clk);
      f_in_valid = 1'b0;
      @(negedge clk);
      if (chk_lat) check_bit("R1 early", f_out_valid, 1'b0);
      @(negedge clk);
      if (chk_lat) check_bit("R1 on time", f_out_valid, 1'b1);
      checks++;
      if (f_res !== er || f_ovf !== eo || f_inv !== ei) begin
         errors++;
         $display("FAIL %s a=%h b=%h got res=%h ovf=%b inv=%b exp res=%h ovf=%b inv=%b",
                  tag, a, b, f_res, f_ovf, f_inv, er, eo, ei);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_bit("R1 reset valid", s_out_valid, 1'b0);
      check_bit("R1 reset valid full", f_out_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      full_op("R2 one plus one",  32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, 1'b1);
      full_op("R3 R4 one minus one", 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 1'b0, 1'b0);
      full_op("R8 max plus max",  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, 1'b0);
      full_op("R6 inf minus inf", 32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 1'b0, 1'b1, 1'b0);
      full_op("R6 signaling nan", 32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b1, 1'b0);
      full_op("R5 quiet nan",     32'h7FC12345, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, 1'b0);
      full_op("R7 neg inf",       32'hFF800000, 32'h3F800000, 1'b0, 32'hFF800000, 1'b0, 1'b0, 1'b0);
      full_op("R2 denormals",     32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 1'b0, 1'b0, 1'b0);
      full_op("R2 tie to even",   32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 1'b0);
      full_op("R2 tie up",        32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, 1'b0);
      full_op("R3 to denormal",   32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, 1'b0, 1'b0, 1'b0);
      full_op("R4 neg zero sum",  32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0);

      @(negedge clk);
      for (int a = 0; a < (1 << SW); a++)
         for (int b = 0; b < (1 << SW); b++)
            issue_small(SW'(a), SW'(b), 1'b0);
      for (int a = 0; a < (1 << SW); a += 2)
         for (int b = 0; b < (1 << SW); b++)
            issue_small(SW'(a), SW'(b), 1'b1);
      s_in_valid = 1'b0;
      repeat (6) @(negedge clk);

      checks++;
      if (popped != issued) begin
         errors++;
         $display("FAIL R1 results %0d exp %0d", popped, issued);
      end
      check_bit("R9 idle ovf", s_ovf, 1'b0);
      check_bit("R9 idle inv", s_inv, 1'b0);
      check_bit("R9 idle valid", s_out_valid, 1'b0);

      summary();
      $finish;
   end
endmodule